// File: doc/BRIEF.md
# Coprocessor Bus Decoder with Mailbox Ports

This block sits between a 32-bit coprocessor bus and the storage and mailboxes that bus can reach. It decodes every byte of a transfer on its own against a fixed, sparse map. The map holds a 128 KiB read-only program window, a 16 KiB work-RAM window and four byte-wide mailbox slots spaced one word apart. It assembles the four bytes little-endian into the read word and masks the result to the requested size. A byte or half-word store is performed as a read-modify-write that writes all four bytes back.

The mailboxes form two one-way sets. Bytes the host writes are read by the coprocessor. Bytes the coprocessor writes are read by the host through a small 16-bit-offset register window. The program window is computed from the address rather than stored, so the whole 128 KiB window is present without a memory array. The RAM window is backed by a parameterised byte store that repeats (aliases) through the window.

Top module: `cpbus_decoder`

## Requirements
- R1: A byte at address A in 0x00000000..0x0001FFFF reads as A[7:0] ^ A[16:9] ^ ROM_SEED (default 0x5A). Writes there change nothing.
- R2: Addresses 0xE0000000..0xE0003FFF reach a read/write byte store of 2**RAM_AW bytes (default 1024), indexed by the low RAM_AW address bits, so the store repeats through the window.
- R3: On the coprocessor side, the byte addresses 0x40000020 + 4*k (k = 0..3) read host mailbox k and write coprocessor mailbox k. These are two separate sets, so a coprocessor write is not seen by a coprocessor read.
- R4: Any other byte address reads as zero, and a write to it is dropped. This includes the bytes between the mailbox slots and everything past the end of a window.
- R5: cp_size 0 is a byte, 1 a half-word, and 2 or 3 a word. The read word is {byte A+3, A+2, A+1, A} (addresses wrap modulo 2**32) and is masked to 8 or 16 bits for the smaller sizes. cp_rdata is zero unless cp_req=1 and cp_we=0.
- R6: A word store completes at the clock edge that ends its cycle, with cp_busy low.
- R7: A byte or half-word store takes two cycles. The first cycle reads the old word at the address and captures it merged with the new low 8 or 16 bits. At the end of the second cycle all four bytes of the merged word are written. The bus inputs in the second cycle are ignored.
- R8: cp_busy is high only in the first cycle of a byte or half-word store, and for exactly one cycle.
- R9: A host read at offset 0x3800 returns coprocessor mailbox 0, at 0x3802 mailbox 1, and at 0x3804 mailbox 3. Any other offset reads zero.
- R10: A host write at offset 0x3802 sets host mailbox 1, and at 0x3804 sets host mailbox 0. Writes at other offsets are dropped, so host mailboxes 2 and 3 stay zero.
- R11: Every write takes effect at the clock edge. A read in the same cycle, from either side, returns the value from before that edge.
- R12: Reset clears all mailboxes and the byte store, and returns the store sequence to its idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cp_req | input | 1 | Coprocessor transfer request |
| cp_we | input | 1 | 1 = store, 0 = load |
| cp_size | input | 2 | Transfer size: 0 byte, 1 half-word, 2/3 word |
| cp_addr | input | 32 | Byte address of the transfer |
| cp_wdata | input | 32 | Store data, low bits used for smaller sizes |
| cp_rdata | output | 32 | Assembled, size-masked load data |
| cp_busy | output | 1 | Read phase of a sub-word store; hold the request |
| host_addr | input | 16 | Host register offset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |

## Verification
Two collisions are provoked on purpose. In the first, the coprocessor stores to a mailbox in the same cycle the host reads that mailbox's offset. In the second, the host writes a mailbox in the cycle the coprocessor loads it. Each read is judged in that cycle against the value from before the edge, and again one cycle later against the new value. The bench also runs random traffic in which host writes land during the read or write phase of sub-word stores to the mailbox area. A behavioural model compares both read buses and the busy flag on every clock.

// File: rtl/cpbus_pkg.sv
package cpbus_pkg;

   localparam int BUS_W = 32;
   localparam int LANES = BUS_W / 8;
   localparam int NPORT = 4;

   // address map
   localparam logic [31:0] ROM_LAST = 32'h0001_FFFF;
   localparam logic [17:0] RAM_TAG  = 18'h3_8000;   // addr[31:14] of the RAM window
   localparam logic [27:0] MBOX_TAG = 28'h400_0002; // addr[31:4] of the mailbox slots

   // host offsets
   localparam logic [15:0] HOST_RD_M0 = 16'h3800;
   localparam logic [15:0] HOST_RD_M1 = 16'h3802;
   localparam logic [15:0] HOST_RD_M3 = 16'h3804;
   localparam logic [15:0] HOST_WR_M1 = 16'h3802;
   localparam logic [15:0] HOST_WR_M0 = 16'h3804;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } xfer_size_t;

   typedef enum logic [1:0] {
      RG_NONE = 2'd0,
      RG_ROM  = 2'd1,
      RG_RAM  = 2'd2,
      RG_MBOX = 2'd3
   } region_t;

   function automatic logic [7:0] rom_pattern(input logic [31:0] a, input logic [7:0] seed);
      return a[7:0] ^ a[16:9] ^ seed;
   endfunction

endpackage

// File: rtl/cpbus_lane_decode.sv
module cpbus_lane_decode
   import cpbus_pkg::*;
#(
   parameter int          RAM_AW   = 10,
   parameter logic [7:0]  ROM_SEED = 8'h5A
) (
   input  logic [31:0]       addr,
   output region_t           region,
   output logic [1:0]        mbox_idx,
   output logic [RAM_AW-1:0] ram_idx,
   output logic [7:0]        rom_data
);

   always_comb begin
      region = RG_NONE;
      if (addr <= ROM_LAST)
         region = RG_ROM;
      else if (addr[31:14] == RAM_TAG)
         region = RG_RAM;
      else if (addr[31:4] == MBOX_TAG && addr[1:0] == 2'b00)
         region = RG_MBOX;
   end

   assign mbox_idx = addr[3:2];
   assign ram_idx  = addr[RAM_AW-1:0];
   assign rom_data = rom_pattern(addr, ROM_SEED);

endmodule

// File: rtl/cpbus_byte_ram.sv
module cpbus_byte_ram #(
   parameter int RAM_AW         = 10,
   parameter int PORTS          = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [PORTS-1:0][RAM_AW-1:0]  idx,
   input  logic [PORTS-1:0]              wr_en,
   input  logic [PORTS-1:0][7:0]         wr_data,
   output logic [PORTS-1:0][7:0]         rd_data
);

   localparam int DEPTH = 1 << RAM_AW;

   if (RAM_AW < 2 || RAM_AW > 14) begin : g_bad_depth
      $error("cpbus_byte_ram: RAM_AW must be 2..14");
   end

   logic [7:0] mem [DEPTH];

   always_comb begin
      for (int p = 0; p < PORTS; p++)
         rd_data[p] = mem[idx[p]];
   end

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int d = 0; d < DEPTH; d++)
               mem[d] <= 8'h00;
         end else begin
            for (int p = 0; p < PORTS; p++)
               if (wr_en[p]) mem[idx[p]] <= wr_data[p];
         end
      end
   end else begin : g_noclear
      always_ff @(posedge clk) begin
         for (int p = 0; p < PORTS; p++)
            if (wr_en[p]) mem[idx[p]] <= wr_data[p];
      end
   end

endmodule

// File: rtl/cpbus_mailbox.sv
module cpbus_mailbox
   import cpbus_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPORT-1:0]       cp_wr_en,
   input  logic [NPORT-1:0][7:0]  cp_wr_data,
   output logic [NPORT-1:0][7:0]  to_cp,
   input  logic [15:0]            host_addr,
   input  logic                   host_wr,
   input  logic [7:0]             host_wdata,
   output logic [7:0]             host_rdata
);

   logic [NPORT-1:0][7:0] to_cp_q;
   logic [NPORT-1:0][7:0] from_cp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_cp_q   <= '0;
         from_cp_q <= '0;
      end else begin
         for (int p = 0; p < NPORT; p++)
            if (cp_wr_en[p]) from_cp_q[p] <= cp_wr_data[p];
         if (host_wr) begin
            case (host_addr)
               HOST_WR_M1: to_cp_q[1] <= host_wdata;
               HOST_WR_M0: to_cp_q[0] <= host_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (host_addr)
         HOST_RD_M0: host_rdata = from_cp_q[0];
         HOST_RD_M1: host_rdata = from_cp_q[1];
         HOST_RD_M3: host_rdata = from_cp_q[3];
         default:    host_rdata = 8'h00;
      endcase
   end

   assign to_cp = to_cp_q;

   // host view changes only after a coprocessor mailbox write (R11)
   p_host_read_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(host_addr) && !$past(|cp_wr_en)) |-> $stable(host_rdata));

   // host can never reach mailboxes 2 and 3 (R10)
   p_spare_mbox_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (to_cp_q[2] == 8'h00) && (to_cp_q[3] == 8'h00));

endmodule

// File: rtl/cpbus_decoder.sv
module cpbus_decoder
   import cpbus_pkg::*;
#(
   parameter int          RAM_AW    = 10,
   parameter logic [7:0]  ROM_SEED  = 8'h5A,
   parameter bit          CLEAR_RAM = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cp_req,
   input  logic        cp_we,
   input  logic [1:0]  cp_size,
   input  logic [31:0] cp_addr,
   input  logic [31:0] cp_wdata,
   output logic [31:0] cp_rdata,
   output logic        cp_busy,
   input  logic [15:0] host_addr,
   input  logic        host_wr,
   input  logic [7:0]  host_wdata,
   output logic [7:0]  host_rdata
);

   typedef enum logic {ST_IDLE = 1'b0, ST_COMMIT = 1'b1} phase_t;

   phase_t      phase_q;
   logic [31:0] hold_addr_q;
   logic [31:0] hold_word_q;

   xfer_size_t  size;
   logic        sub_word;
   logic        commit;
   logic        wr_go;
   logic [31:0] lane_base;
   logic [31:0] wr_word;
   logic [31:0] word_rd;
   logic [31:0] merged;

   assign size      = xfer_size_t'(cp_size);
   assign sub_word  = (size == SZ_BYTE) || (size == SZ_HALF);
   assign commit    = (phase_q == ST_COMMIT);
   assign cp_busy   = !commit && cp_req && cp_we && sub_word;
   assign wr_go     = commit || (cp_req && cp_we && !sub_word);
   assign lane_base = commit ? hold_addr_q : cp_addr;
   assign wr_word   = commit ? hold_word_q : cp_wdata;

   // per-lane decode
   region_t                      lane_rg   [LANES];
   logic [1:0]                   lane_mbox [LANES];
   logic [7:0]                   lane_rom  [LANES];
   logic [LANES-1:0][RAM_AW-1:0] lane_ram;
   logic [LANES-1:0][7:0]        lane_rd;
   logic [LANES-1:0][7:0]        ram_rd;
   logic [LANES-1:0]             ram_we;
   logic [LANES-1:0][7:0]        ram_wd;
   logic [NPORT-1:0][7:0]        host_side;
   logic [NPORT-1:0]             mbox_we;
   logic [NPORT-1:0][7:0]        mbox_wd;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      cpbus_lane_decode #(
         .RAM_AW   (RAM_AW),
         .ROM_SEED (ROM_SEED)
      ) u_dec (
         .addr     (lane_base + 32'(g)),
         .region   (lane_rg[g]),
         .mbox_idx (lane_mbox[g]),
         .ram_idx  (lane_ram[g]),
         .rom_data (lane_rom[g])
      );

      always_comb begin
         case (lane_rg[g])
            RG_ROM:  lane_rd[g] = lane_rom[g];
            RG_RAM:  lane_rd[g] = ram_rd[g];
            RG_MBOX: lane_rd[g] = host_side[lane_mbox[g]];
            default: lane_rd[g] = 8'h00;
         endcase
      end

      assign ram_we[g] = wr_go && (lane_rg[g] == RG_RAM);
      assign ram_wd[g] = wr_word[8*g +: 8];
   end

   always_comb begin
      mbox_we = '0;
      mbox_wd = '0;
      for (int l = 0; l < LANES; l++) begin
         if (wr_go && lane_rg[l] == RG_MBOX) begin
            mbox_we[lane_mbox[l]] = 1'b1;
            mbox_wd[lane_mbox[l]] = wr_word[8*l +: 8];
         end
      end
   end

   cpbus_byte_ram #(
      .RAM_AW         (RAM_AW),
      .PORTS          (LANES),
      .CLEAR_ON_RESET (CLEAR_RAM)
   ) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (lane_ram),
      .wr_en   (ram_we),
      .wr_data (ram_wd),
      .rd_data (ram_rd)
   );

   cpbus_mailbox u_mbox (
      .clk        (clk),
      .rst_n      (rst_n),
      .cp_wr_en   (mbox_we),
      .cp_wr_data (mbox_wd),
      .to_cp      (host_side),
      .host_addr  (host_addr),
      .host_wr    (host_wr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata)
   );

   // little-endian assembly and size mask
   assign word_rd = lane_rd;

   always_comb begin
      case (size)
         SZ_BYTE: merged = {word_rd[31:8],  cp_wdata[7:0]};
         SZ_HALF: merged = {word_rd[31:16], cp_wdata[15:0]};
         default: merged = cp_wdata;
      endcase
   end

   always_comb begin
      cp_rdata = 32'h0;
      if (cp_req && !cp_we) begin
         case (size)
            SZ_BYTE: cp_rdata = {24'h0, word_rd[7:0]};
            SZ_HALF: cp_rdata = {16'h0, word_rd[15:0]};
            default: cp_rdata = word_rd;
         endcase
      end
   end

   // read-modify-write sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= ST_IDLE;
         hold_addr_q <= '0;
         hold_word_q <= '0;
      end else if (commit) begin
         phase_q <= ST_IDLE;
      end else if (cp_busy) begin
         phase_q     <= ST_COMMIT;
         hold_addr_q <= cp_addr;
         hold_word_q <= merged;
      end
   end

   // busy never spans two cycles (R8)
   p_busy_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cp_busy |=> !cp_busy);

   // a word store never stalls (R6)
   p_word_no_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_req && cp_we && !sub_word) |-> !cp_busy);

   // byte and half loads are masked (R5)
   p_byte_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (size == SZ_BYTE) |-> (cp_rdata[31:8] == 24'h0));
   p_half_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (size == SZ_HALF) |-> (cp_rdata[31:16] == 16'h0));

   // loads return nothing when no load is requested (R5)
   p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(cp_req && !cp_we) |-> (cp_rdata == 32'h0));

endmodule

// File: tb/test_cpbus_decoder.sv
module test_cpbus_decoder;

   localparam int MDEPTH = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cp_req = 1'b0;
   logic        cp_we = 1'b0;
   logic [1:0]  cp_size = 2'd2;
   logic [31:0] cp_addr = '0;
   logic [31:0] cp_wdata = '0;
   logic [31:0] cp_rdata;
   logic        cp_busy;
   logic [15:0] host_addr = '0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;

   always #10 clk = ~clk;

   cpbus_decoder i_cpbus_decoder (
      .clk(clk), .rst_n(rst_n), .cp_req(cp_req), .cp_we(cp_we), .cp_size(cp_size),
      .cp_addr(cp_addr), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_busy(cp_busy),
      .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   // ---------------- reference model ----------------
   logic [7:0]  m_ram [MDEPTH];
   logic [7:0]  m_hm [4];
   logic [7:0]  m_cm [4];
   bit          m_commit;
   logic [31:0] m_addr;
   logic [31:0] m_word;

   function automatic logic [7:0] mbyte(input logic [31:0] a);
      if (a <= 32'h0001FFFF) return a[7:0] ^ a[16:9] ^ 8'h5A;
      if (a >= 32'hE0000000 && a <= 32'hE0003FFF) return m_ram[a % MDEPTH];
      if (a == 32'h40000020) return m_hm[0];
      if (a == 32'h40000024) return m_hm[1];
      if (a == 32'h40000028) return m_hm[2];
      if (a == 32'h4000002C) return m_hm[3];
      return 8'h00;
   endfunction

   function automatic logic [31:0] mword(input logic [31:0] a);
      return {mbyte(a + 32'd3), mbyte(a + 32'd2), mbyte(a + 32'd1), mbyte(a)};
   endfunction

   task automatic mput(input logic [31:0] a, input logic [7:0] d);
      if (a >= 32'hE0000000 && a <= 32'hE0003FFF) m_ram[a % MDEPTH] = d;
      else if (a == 32'h40000020) m_cm[0] = d;
      else if (a == 32'h40000024) m_cm[1] = d;
      else if (a == 32'h40000028) m_cm[2] = d;
      else if (a == 32'h4000002C) m_cm[3] = d;
   endtask

   task automatic mwrite4(input logic [31:0] a, input logic [31:0] w);
      for (int k = 0; k < 4; k++) mput(a + 32'(k), w[8*k +: 8]);
   endtask

   function automatic logic [31:0] exp_rdata();
      logic [31:0] w;
      if (!(cp_req && !cp_we)) return 32'h0;
      w = mword(cp_addr);
      if (cp_size == 2'd0) return {24'h0, w[7:0]};
      if (cp_size == 2'd1) return {16'h0, w[15:0]};
      return w;
   endfunction

   function automatic logic [7:0] exp_host();
      case (host_addr)
         16'h3800: return m_cm[0];
         16'h3802: return m_cm[1];
         16'h3804: return m_cm[3];
         default:  return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      logic [31:0] old;
      if (!rst_n) begin
         for (int i = 0; i < MDEPTH; i++) m_ram[i] = 8'h00;
         for (int i = 0; i < 4; i++) begin m_hm[i] = 8'h00; m_cm[i] = 8'h00; end
         m_commit = 1'b0;
      end else begin
         if (m_commit) begin
            mwrite4(m_addr, m_word);
            m_commit = 1'b0;
         end else if (cp_req && cp_we) begin
            if (cp_size >= 2'd2) mwrite4(cp_addr, cp_wdata);
            else begin
               old = mword(cp_addr);
               m_word = (cp_size == 2'd0) ? {old[31:8], cp_wdata[7:0]} : {old[31:16], cp_wdata[15:0]};
               m_addr = cp_addr;
               m_commit = 1'b1;
            end
         end
         if (host_wr) begin
            if (host_addr == 16'h3802) m_hm[1] = host_wdata;
            if (host_addr == 16'h3804) m_hm[0] = host_wdata;
         end
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         chk("R5 model cp_rdata", cp_rdata, exp_rdata());
         chk("R9 model host_rdata", {24'h0, host_rdata}, {24'h0, exp_host()});
         chk("R8 model cp_busy", {31'h0, cp_busy},
             {31'h0, !m_commit && cp_req && cp_we && (cp_size < 2'd2)});
      end
   end

   task automatic drive(input bit rq, input bit we, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] d, input bit hw, input logic [15:0] ha, input logic [7:0] hd);
      @(posedge clk); #2;
      cp_req = rq; cp_we = we; cp_size = sz; cp_addr = a; cp_wdata = d;
      host_wr = hw; host_addr = ha; host_wdata = hd;
   endtask

   task automatic rd(input logic [1:0] sz, input logic [31:0] a);
      drive(1, 0, sz, a, 32'h0, 0, 16'h0, 8'h0);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
      drive(1, 1, sz, a, d, 0, 16'h0, 8'h0);
      if (sz < 2'd2) drive(1, 1, sz, a, d, 0, 16'h0, 8'h0);
   endtask

   task automatic hwr(input logic [15:0] ha, input logic [7:0] hd);
      drive(0, 0, 2'd2, 32'h0, 32'h0, 1, ha, hd);
   endtask

   task automatic hrd(input logic [15:0] ha);
      drive(0, 0, 2'd2, 32'h0, 32'h0, 0, ha, 8'h0);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      cmp_on = 1'b1;

      // R12 reset state
      rd(2'd2, 32'h40000020); chk("R12 mailbox after reset", cp_rdata, 32'h0);
      rd(2'd2, 32'hE0000004); chk("R12 RAM after reset", cp_rdata, 32'h0);
      hrd(16'h3800);          chk("R12 host view after reset", {24'h0, host_rdata}, 32'h0);
      chk("R12 busy after reset", {31'h0, cp_busy}, 32'h0);

      // R1 program window
      rd(2'd2, 32'h00000100); chk("R1 rom word", cp_rdata, 32'h59585B5A);
      rd(2'd2, 32'h0001FFFE); chk("R1 rom end boundary", cp_rdata, 32'h00005A5B);
      wr(2'd2, 32'h00000100, 32'hFFFFFFFF);
      rd(2'd2, 32'h00000100); chk("R1 rom write ignored", cp_rdata, 32'h59585B5A);
      rd(2'd3, 32'h00000100); chk("R5 size 3 acts as word", cp_rdata, 32'h59585B5A);

      // R2 / R5 / R6 RAM
      drive(1, 1, 2'd2, 32'hE0000010, 32'h11223344, 0, 16'h0, 8'h0);
      @(negedge clk); chk("R6 word store no busy", {31'h0, cp_busy}, 32'h0);
      rd(2'd2, 32'hE0000010); chk("R6 word store visible next cycle", cp_rdata, 32'h11223344);
      rd(2'd0, 32'hE0000011); chk("R5 byte load", cp_rdata, 32'h00000033);
      rd(2'd1, 32'hE0000012); chk("R5 half load", cp_rdata, 32'h00001122);
      rd(2'd2, 32'hE000000E); chk("R5 unaligned word", cp_rdata, 32'h33440000);
      rd(2'd2, 32'hE0000410); chk("R2 alias", cp_rdata, 32'h11223344);
      wr(2'd2, 32'hE0003FFE, 32'hAABBCCDD);
      rd(2'd2, 32'hE0003FFE); chk("R2 window end", cp_rdata, 32'h0000CCDD);
      rd(2'd2, 32'hE00003FE); chk("R2 alias wrap", cp_rdata, 32'h0000CCDD);

      // R7 / R8 read-modify-write
      drive(1, 1, 2'd0, 32'hE0000010, 32'hFFFFFF99, 0, 16'h0, 8'h0);
      @(negedge clk); chk("R8 busy in read phase", {31'h0, cp_busy}, 32'h1);
      drive(1, 1, 2'd0, 32'hE0000010, 32'h00000055, 0, 16'h0, 8'h0);
      @(negedge clk); chk("R8 busy drops in commit", {31'h0, cp_busy}, 32'h0);
      rd(2'd2, 32'hE0000010); chk("R7 byte merge, commit inputs ignored", cp_rdata, 32'h11223399);
      wr(2'd1, 32'hE0000011, 32'h0000BEEF);
      rd(2'd2, 32'hE0000010); chk("R7 half merge", cp_rdata, 32'h11BEEF99);
      rd(2'd0, 32'hE0000014); chk("R7 upper bytes rewritten unchanged", cp_rdata, 32'h0);

      // R10 / R3 host to coprocessor
      hwr(16'h3804, 8'hA5);
      hwr(16'h3802, 8'h3C);
      hwr(16'h3800, 8'h77);
      hwr(16'h3806, 8'h88);
      rd(2'd2, 32'h40000020); chk("R10 host write 0x3804 to mailbox 0", cp_rdata, 32'h000000A5);
      rd(2'd2, 32'h40000024); chk("R10 host write 0x3802 to mailbox 1", cp_rdata, 32'h0000003C);
      rd(2'd0, 32'h40000028); chk("R10 mailbox 2 untouched", cp_rdata, 32'h0);
      rd(2'd0, 32'h4000002C); chk("R10 mailbox 3 untouched", cp_rdata, 32'h0);
      rd(2'd2, 32'h4000001F); chk("R3 straddling mailbox read", cp_rdata, 32'h0000A500);

      // R3 / R9 coprocessor to host
      wr(2'd2, 32'h40000020, 32'h12345611);
      hrd(16'h3800); chk("R9 host reads mailbox 0", {24'h0, host_rdata}, 32'h11);
      rd(2'd2, 32'h40000020); chk("R3 separate mailbox sets", cp_rdata, 32'h000000A5);
      wr(2'd2, 32'h4000002A, 32'hCC22BBAA);
      hrd(16'h3804); chk("R9 host 0x3804 reads mailbox 3", {24'h0, host_rdata}, 32'h22);
      wr(2'd0, 32'h40000024, 32'h000000E1);
      hrd(16'h3802); chk("R9 host reads mailbox 1 after byte store", {24'h0, host_rdata}, 32'hE1);
      hrd(16'h3806); chk("R9 other offset reads zero", {24'h0, host_rdata}, 32'h0);

      // R4 unmapped
      rd(2'd2, 32'h12345678); chk("R4 unmapped read", cp_rdata, 32'h0);
      wr(2'd2, 32'h80000000, 32'hFFFFFFFF);
      rd(2'd2, 32'h80000000); chk("R4 unmapped write dropped", cp_rdata, 32'h0);
      rd(2'd1, 32'h40000021); chk("R4 gap between mailboxes", cp_rdata, 32'h0);

      // R5 no request
      drive(0, 0, 2'd2, 32'h00000100, 32'h0, 0, 16'h0, 8'h0);
      @(negedge clk); chk("R5 no request reads zero", cp_rdata, 32'h0);

      // R11 same-cycle collisions
      drive(1, 1, 2'd2, 32'h40000020, 32'h0000005E, 0, 16'h3800, 8'h0);
      @(negedge clk); chk("R11 host read sees old value", {24'h0, host_rdata}, 32'h11);
      hrd(16'h3800); chk("R11 host read sees new value", {24'h0, host_rdata}, 32'h5E);
      drive(1, 0, 2'd0, 32'h40000020, 32'h0, 1, 16'h3804, 8'h6B);
      @(negedge clk); chk("R11 cp read sees old value", cp_rdata, 32'h000000A5);
      rd(2'd0, 32'h40000020); chk("R11 cp read sees new value", cp_rdata, 32'h0000006B);

      // random traffic checked by the model every cycle
      for (int n = 0; n < 600; n++) begin
         logic [31:0] a;
         logic [1:0]  sz;
         logic [15:0] ha;
         int sel;
         sel = $urandom % 6;
         case (sel)
            0: a = 32'h00000100 + ($urandom % 8);
            1: a = 32'h0001FFFC + ($urandom % 6);
            2: a = 32'hE0000000 + ($urandom % 24);
            3: a = 32'hE0003FFC + ($urandom % 6);
            4: a = 32'h4000001E + ($urandom % 16);
            default: a = 32'h90000000 + ($urandom % 4);
         endcase
         sz = 2'($urandom % 4);
         ha = 16'h3800 + 16'(2 * ($urandom % 4));
         if ($urandom % 2 == 0) begin
            drive(1, 1, sz, a, $urandom, ($urandom % 3) == 0, ha, 8'($urandom));
            if (sz < 2'd2) drive(1, 1, sz, a, $urandom, ($urandom % 3) == 0, ha, 8'($urandom));
         end else begin
            drive(1, 0, sz, a, 32'h0, ($urandom % 3) == 0, ha, 8'($urandom));
         end
      end
      drive(0, 0, 2'd2, 32'h0, 32'h0, 0, 16'h0, 8'h0);
      @(negedge clk);
      finish_run();
   end

endmodule